// File: doc/BRIEF.md
# Flash Query-Mode Read Overlay

This block sits on the read path between a host bus and an array of ROM chips. It watches the host's write traffic for a pair of command patterns. One pattern puts the array into a query mode and the other takes it out. While query mode is active, a host read aimed at an installed chip slot gets a 16-bit word from a small built-in query table instead of ROM data. Every other read goes to the ROM with its address forced to a halfword boundary.

The number of installed slots comes from the low seven bits of a cartridge identification word. When the host says no identification is present, the block uses a built-in default. The table content is computed at elaboration time. The table lookup uses the low address bits. Words beyond the table's length read as zero.

Top module: `flash_query_overlay`

## Requirements
- R1: A write (`wr_en` high at a clock edge) with `wr_data` equal to 0x0098 and `wr_addr[15:0]` equal to 0x00AA sets `query_mode` from the next cycle on. The upper address bits are ignored.
- R2: A write with `wr_data` equal to 0x00F0 and `wr_addr[15:0]` equal to 0x0000 clears `query_mode` from the next cycle on. The upper address bits are ignored.
- R3: Any other write leaves `query_mode` unchanged. A cycle without a write also leaves it unchanged. `wr_ack` equals `wr_en` in every cycle.
- R4: While `rst_n` is low, `query_mode` is 0.
- R5: A read is overridden only when `query_mode` is 1 and `rd_addr[28:26]` is less than the slot count. The slot count is the effective ID bits [6:0].
- R6: An overridden read returns table entry `rd_addr[15:1]`. Entry i, for i below 48, has upper byte 0x00 and lower byte ((i*29) mod 256) XOR 0xA5. Entries 48 and above read as 0x0000.
- R7: An overridden read grants min(`rd_len`, 2) bytes. A read that is not overridden grants `rd_len` unchanged.
- R8: `rom_addr` always equals `rd_addr` AND 0x1FFFFFFE. A read that is not overridden returns `rom_rdata` on `rd_data`.
- R9: When `card_id_valid` is 0, the effective ID is 0x5504, which gives four slots. When it is 1, the effective ID is `card_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 32 | Host write address |
| wr_data | input | 16 | Host write data |
| wr_ack | output | 1 | Write acknowledge, always granted |
| rd_addr | input | 32 | Host read address |
| rd_len | input | 3 | Requested read length in bytes |
| card_id | input | 16 | Cartridge identification word |
| card_id_valid | input | 1 | High when `card_id` is supplied |
| rom_addr | output | 32 | Halfword-aligned address to the ROM array |
| rom_rdata | input | 16 | Data returned by the ROM array |
| rd_data | output | 16 | Read data to the host |
| rd_len_grant | output | 3 | Granted read length in bytes |
| query_mode | output | 1 | Query mode flag |

## Verification
The block holds only one bit of state, the mode flag, so any error in its decode shows at the ports one cycle after the offending write. It appears on `query_mode` itself, and on the next read to a low slot, which returns either a table word or ROM data. A wrong slot compare or a wrong default ID shows in the same cycle as the read, through the data source and the length grant. The bench therefore reads at slot values on both sides of the count boundary and at table indices on both sides of the table end.

// File: rtl/fqo_pkg.sv
package fqo_pkg;

   localparam int unsigned FQO_ADDR_W = 32;
   localparam int unsigned FQO_DATA_W = 16;

   typedef struct packed {
      logic [15:0] loc;
      logic [15:0] data;
   } fqo_cmd_t;

   localparam fqo_cmd_t FQO_ENTER = '{loc: 16'h00AA, data: 16'h0098};
   localparam fqo_cmd_t FQO_LEAVE = '{loc: 16'h0000, data: 16'h00F0};

   localparam logic [15:0] FQO_DEFAULT_ID = 16'h5504;

   function automatic logic [15:0] fqo_entry(input int unsigned idx);
      logic [7:0] lo;
      lo = 8'(idx * 29) ^ 8'hA5;
      return {8'h00, lo};
   endfunction

endpackage

// File: rtl/fqo_cmd_decode.sv
module fqo_cmd_decode
   import fqo_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              mode
);
   localparam int unsigned LOC_W = 16;

   initial begin
      a_cfg_width : assert (ADDR_W >= LOC_W && DATA_W >= 16)
         else $error("fqo_cmd_decode: widths too small");
   end

   logic [LOC_W-1:0] loc;
   logic             hit_enter;
   logic             hit_leave;
   logic             mode_q;

   assign loc       = wr_addr[LOC_W-1:0];
   assign hit_enter = wr_en && (loc == FQO_ENTER.loc) && (wr_data == DATA_W'(FQO_ENTER.data));
   assign hit_leave = wr_en && (loc == FQO_LEAVE.loc) && (wr_data == DATA_W'(FQO_LEAVE.data));

   always_ff @(posedge clk) begin
      if (!rst_n)         mode_q <= 1'b0;
      else if (hit_enter) mode_q <= 1'b1;
      else if (hit_leave) mode_q <= 1'b0;
   end

   assign mode = mode_q;

   a_r1_enter : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:0] == 16'h00AA && wr_data == DATA_W'(16'h0098)) |=> mode);
   a_r2_leave : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:0] == 16'h0000 && wr_data == DATA_W'(16'h00F0)) |=> !mode);
   a_r3_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || !((wr_addr[15:0] == 16'h00AA && wr_data == DATA_W'(16'h0098)) ||
                   (wr_addr[15:0] == 16'h0000 && wr_data == DATA_W'(16'h00F0))))
      |=> $stable(mode));
   a_r4_reset : assert property (@(posedge clk) !rst_n |=> !mode);

endmodule

// File: rtl/fqo_slot_gate.sv
module fqo_slot_gate
   import fqo_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned SLOT_LSB = 26,
   parameter int unsigned SLOT_W   = 3,
   parameter int unsigned COUNT_W  = 7
) (
   input  logic              mode,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [15:0]       card_id,
   input  logic              card_id_valid,
   output logic              hit
);
   localparam int unsigned CMP_W = (COUNT_W > SLOT_W) ? COUNT_W : SLOT_W;

   initial begin
      a_cfg_slot : assert (SLOT_LSB + SLOT_W <= ADDR_W && COUNT_W <= 16)
         else $error("fqo_slot_gate: field out of range");
   end

   logic [15:0]        eff_id;
   logic [SLOT_W-1:0]  slot;
   logic [CMP_W-1:0]   slot_x;
   logic [CMP_W-1:0]   count_x;

   assign eff_id  = card_id_valid ? card_id : FQO_DEFAULT_ID;
   assign slot    = rd_addr[SLOT_LSB +: SLOT_W];
   assign slot_x  = CMP_W'(slot);
   assign count_x = CMP_W'(eff_id[COUNT_W-1:0]);
   assign hit     = mode && (slot_x < count_x);

   always_comb begin
      if (!mode) a_r5_idle : assert (!hit);
   end

endmodule

// File: rtl/fqo_query_rom.sv
module fqo_query_rom
   import fqo_pkg::*;
#(
   parameter int unsigned IDX_W       = 15,
   parameter int unsigned TABLE_WORDS = 48
) (
   input  logic [IDX_W-1:0] idx,
   output logic [15:0]      word
);
   initial begin
      a_cfg_depth : assert (TABLE_WORDS >= 1 && TABLE_WORDS <= 1024 && TABLE_WORDS <= (1 << IDX_W))
         else $error("fqo_query_rom: bad depth");
   end

   logic [15:0] tbl [TABLE_WORDS];

   for (genvar i = 0; i < TABLE_WORDS; i++) begin : g_entry
      assign tbl[i] = fqo_entry(i);
   end

   always_comb begin
      word = 16'h0000;
      for (int j = 0; j < TABLE_WORDS; j++) begin
         if (32'(idx) == j) word = tbl[j];
      end
   end

   always_comb begin
      if (32'(idx) >= TABLE_WORDS) a_r6_beyond_zero : assert (word == 16'h0000);
   end

endmodule

// File: rtl/flash_query_overlay.sv
module flash_query_overlay
   import fqo_pkg::*;
#(
   parameter int unsigned        ADDR_W      = 32,
   parameter int unsigned        DATA_W      = 16,
   parameter int unsigned        LEN_W       = 3,
   parameter int unsigned        TABLE_WORDS = 48,
   parameter logic [ADDR_W-1:0]  ROM_MASK    = 32'h1FFF_FFFE,
   parameter bit                 RD_REG      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ack,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [LEN_W-1:0]  rd_len,
   input  logic [15:0]       card_id,
   input  logic              card_id_valid,
   output logic [ADDR_W-1:0] rom_addr,
   input  logic [DATA_W-1:0] rom_rdata,
   output logic [DATA_W-1:0] rd_data,
   output logic [LEN_W-1:0]  rd_len_grant,
   output logic              query_mode
);
   localparam int unsigned IDX_W   = 15;
   localparam int unsigned WORD_LEN = 2;

   initial begin
      a_cfg_top : assert (DATA_W == 16 && LEN_W >= 2 && ADDR_W >= 29)
         else $error("flash_query_overlay: unsupported widths");
   end

   logic              mode;
   logic              hit;
   logic [15:0]       qword;
   logic [DATA_W-1:0] data_c;
   logic [LEN_W-1:0]  len_c;

   fqo_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .mode(mode)
   );

   fqo_slot_gate #(.ADDR_W(ADDR_W)) u_gate (
      .mode(mode), .rd_addr(rd_addr), .card_id(card_id),
      .card_id_valid(card_id_valid), .hit(hit)
   );

   fqo_query_rom #(.IDX_W(IDX_W), .TABLE_WORDS(TABLE_WORDS)) u_rom (
      .idx(rd_addr[IDX_W:1]), .word(qword)
   );

   assign wr_ack     = wr_en;
   assign query_mode = mode;
   assign rom_addr   = rd_addr & ROM_MASK;

   always_comb begin
      if (hit) begin
         data_c = qword;
         len_c  = (rd_len > LEN_W'(WORD_LEN)) ? LEN_W'(WORD_LEN) : rd_len;
      end else begin
         data_c = rom_rdata;
         len_c  = rd_len;
      end
   end

   if (RD_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_data      <= '0;
            rd_len_grant <= '0;
         end else begin
            rd_data      <= data_c;
            rd_len_grant <= len_c;
         end
      end
   end else begin : g_comb
      assign rd_data      = data_c;
      assign rd_len_grant = len_c;
   end

   always_comb begin
      a_r8_align : assert (rom_addr[0] == 1'b0);
      if (hit) a_r7_len_cap : assert (len_c <= LEN_W'(WORD_LEN) && len_c <= rd_len);
      else     a_r7_len_pass : assert (len_c == rd_len);
   end

endmodule

// File: tb/tb_flash_query_overlay.sv
module tb_flash_query_overlay;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [31:0] wr_addr;
   logic [15:0] wr_data;
   logic        wr_ack;
   logic [31:0] rd_addr;
   logic [2:0]  rd_len;
   logic [15:0] card_id;
   logic        card_id_valid;
   logic [31:0] rom_addr;
   logic [15:0] rom_rdata;
   logic [15:0] rd_data;
   logic [2:0]  rd_len_grant;
   logic        query_mode;

   int tests = 0;
   int fails = 0;
   bit model_mode = 1'b0;

   always #10 clk = ~clk;

   assign rom_rdata = rom_addr[16:1] ^ 16'h3C3C;

   flash_query_overlay dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_ack(wr_ack), .rd_addr(rd_addr), .rd_len(rd_len), .card_id(card_id),
      .card_id_valid(card_id_valid), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
      .rd_data(rd_data), .rd_len_grant(rd_len_grant), .query_mode(query_mode)
   );

   function automatic logic [15:0] exp_table(int unsigned i);
      if (i >= 48) return 16'h0000;
      return {8'h00, 8'((i * 29) % 256) ^ 8'hA5};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(logic [31:0] a, logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      #1 check("R3 ack", {31'd0, wr_ack}, 32'd1);
      @(posedge clk);
      if (a[15:0] == 16'h00AA && d == 16'h0098) model_mode = 1'b1;
      else if (a[15:0] == 16'h0000 && d == 16'h00F0) model_mode = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
      #1 check("R1/R2/R3 mode", {31'd0, query_mode}, {31'd0, model_mode});
   endtask

   task automatic do_read(logic [31:0] a, logic [2:0] len, logic [15:0] id, logic idv);
      logic [15:0] eid;
      bit ovr;
      @(negedge clk);
      rd_addr = a; rd_len = len; card_id = id; card_id_valid = idv;
      #1;
      eid = idv ? id : 16'h5504;
      ovr = model_mode && ({4'd0, a[28:26]} < eid[6:0]);
      check("R8 rom_addr", rom_addr, a & 32'h1FFF_FFFE);
      if (ovr) begin
         check("R5/R6/R9 table word", {16'd0, rd_data}, {16'd0, exp_table(a[15:1])});
         check("R7 len cap", {29'd0, rd_len_grant}, {29'd0, (len > 3'd2) ? 3'd2 : len});
      end else begin
         check("R5/R8/R9 rom data", {16'd0, rd_data}, {16'd0, (a[16:1] & 16'hFFFF) ^ 16'h3C3C});
         check("R7 len pass", {29'd0, rd_len_grant}, {29'd0, len});
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      rd_addr = '0; rd_len = 3'd4; card_id = '0; card_id_valid = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R4 reset mode", {31'd0, query_mode}, 32'd0);
      rst_n = 1'b1;

      // directed: not in mode, reads go to ROM
      do_read(32'hE000_0013, 3'd4, 16'h0000, 1'b0);
      // enter with junk upper bits (R1)
      do_write(32'hABCD_00AA, 16'h0098);
      check("R1 entered", {31'd0, query_mode}, 32'd1);
      // default ID: slots 0..3 overridden, slot 4 not (R9)
      do_read(32'h0C00_0002, 3'd4, 16'h0000, 1'b0);
      do_read(32'h1000_0002, 3'd4, 16'h0000, 1'b0);
      // table end boundary (R6)
      do_read(32'h0000_005E, 3'd1, 16'h0002, 1'b1);
      do_read(32'h0000_0060, 3'd4, 16'h0002, 1'b1);
      // zero slots supplied: nothing overridden (R5)
      do_read(32'h0000_0004, 3'd4, 16'h0080, 1'b1);
      // near-miss writes (R3)
      do_write(32'h0000_0000, 16'h0098);
      do_write(32'h0000_00AA, 16'h00F0);
      check("R3 unchanged", {31'd0, query_mode}, 32'd1);
      // leave (R2)
      do_write(32'h7777_0000, 16'h00F0);
      check("R2 left", {31'd0, query_mode}, 32'd0);
      do_read(32'h0000_0004, 3'd4, 16'h0007, 1'b1);

      for (int n = 0; n < 600; n++) begin
         int unsigned r = $urandom % 8;
         logic [31:0] a = $urandom;
         if (r == 0)      do_write({a[31:16], 16'h00AA}, 16'h0098);
         else if (r == 1) do_write({a[31:16], 16'h0000}, 16'h00F0);
         else if (r == 2) do_write(a, 16'($urandom));
         else begin
            logic [31:0] ra = {a[31:16], 9'd0, a[6:0]};
            do_read(ra, 3'($urandom), {9'($urandom), 4'd0, 3'($urandom)}, 1'($urandom));
         end
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #2_000_000;
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule